// File: doc/BRIEF.md
# Power-on reset sequencer

This block takes a digitized indication that the core supply is good. From it, the block produces an internal reset that is released in three timed stages. First a short wait lets the bias circuits settle. Next a power-up timer runs; it is inserted every time the supply comes back. Last comes a clock start-up wait whose length depends on the clock source that was latched from configuration inputs when power came on. Only after all three stages does the block enable the system clock and code execution. Every delay is counted in a free-running low-frequency timer clock, and every length is a parameter.

A second, lower comparator level marks the point below which the supply counts as truly gone. A power-on event fires once on a good supply and cannot fire again until the supply has fallen below that lower level. The block also keeps three reset-cause flags.
- A power-on event clears the power-on and brown-out flags.
- The same event sets a supply-event flag.
- Software rewrites all three flags through a write port.

Brown-out and other reset requests hold the internal reset while they last. They do not disturb the staged sequence or the flags.

Top module: `por_sequencer`

## Requirements
- R1: After `rst_n`, the detector is armed. The first cycle with both `vdd_ok` and `vdd_live` high is a power-on event. An event starts the sequence: the state after that edge is the bias wait.
- R2: Once an event has fired, the detector stays disarmed until `vdd_live` is seen low. A fall and rise of `vdd_ok` while `vdd_live` stays high restarts the delays. It does not change the flags and does not re-latch the clock selection.
- R3: On a power-on event, `cfg_clk_sel` and `cfg_long_start` are latched. `clk_sel_q` shows the latched selection from the next cycle on.
- R4: The stages run in the order bias wait (BIAS_CYC cycles), power-up wait (PWRT_CYC cycles), clock wait. The power-up wait is never skipped, including on a restart after a supply dip. If `vdd_ok` goes high before edge E0, `exec_en` is first high after edge E0 + BIAS_CYC + PWRT_CYC + clock wait.
- R5: The clock wait is set by the latched selection.
  - 0 selects XTAL_CYC (crystal).
  - 1 selects INTOSC_CYC (internal oscillator).
  - 2 or 3 selects RC_CYC (RC settle).
  - A latched `cfg_long_start` of 1 doubles the count.
- R6: `clk_en` rises only when the whole sequence has finished. `exec_en` is never high while `clk_en` is low.
- R7: If `vdd_ok` is sampled low in any state, including the running state, then after that edge `rst_int` is 1 and `clk_en` is 0. The next rise runs the full sequence from its start.
- R8: While `bor_event` or `ext_rst_req` is high, `rst_int` is 1 and `exec_en` is 0 from the next cycle on. Neither input changes `clk_en`, the sequence or the flags.
- R9: A power-on event sets `rst_flags` to 3'b100. Bit 0 is the power-on flag (cleared), bit 1 is the brown-out flag (cleared) and bit 2 is the supply-event flag (set). The event takes priority over a software write in the same cycle.
- R10: A cycle with `sw_we` high loads `sw_wdata` into `rst_flags`, using the same bit positions. Without a write or an event, the flags hold.
- R11: During and right after `rst_n`, the outputs are `rst_int`=1, `clk_en`=0, `exec_en`=0, `rst_flags`=0 and `clk_sel_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-frequency timer clock |
| rst_n | input | 1 | Asynchronous initialisation of the block, active low |
| vdd_ok | input | 1 | Supply above the power-on release threshold |
| vdd_live | input | 1 | Supply above the rearm level; low means power is truly gone |
| bor_event | input | 1 | Brown-out reset request |
| ext_rst_req | input | 1 | Other reset sources combined |
| cfg_clk_sel | input | 2 | Clock source from configuration bits |
| cfg_long_start | input | 1 | Selects the doubled start-up count for the chosen source |
| sw_we | input | 1 | Software write strobe for the flags |
| sw_wdata | input | 3 | Flag write data {supply-event, brown-out, power-on} |
| rst_int | output | 1 | Internal reset, active high |
| clk_en | output | 1 | System clock release |
| exec_en | output | 1 | Code execution enable |
| clk_sel_q | output | 2 | Latched clock selection |
| rst_flags | output | 3 | Reset-cause flags {supply-event, brown-out, power-on} |

## Verification
The hardware flag update caused by a power-on event can land in the same cycle as a software write to the flags. The bench provokes this by raising the supply from a true power-down on the same negative edge that drives `sw_we` with data that would set the power-on flag. It expects the hardware values 3'b100 afterwards. The behavioural model in the bench applies the same priority every cycle, and the per-cycle comparison judges the outcome. Brown-out holds that overlap the running state are judged the same way: the flags and `clk_en` are expected to stay put while `exec_en` drops.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE_RESET = 3'd0,
    ST_BIAS_WAIT  = 3'd1,
    ST_PWRT_WAIT  = 3'd2,
    ST_CLK_WAIT   = 3'd3,
    ST_RUN        = 3'd4
  } seq_state_t;

  localparam int FLAG_POR    = 0;
  localparam int FLAG_BOR    = 1;
  localparam int FLAG_VDDEVT = 2;
  localparam int FLAG_W      = 3;
  localparam int SEL_W       = 2;

  // a zero-length stage still occupies one timer cycle
  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // clock start-up wait in timer cycles for a latched selection
  function automatic int unsigned start_wait(input logic [SEL_W-1:0] sel,
                                             input logic long_sel,
                                             input int unsigned xt,
                                             input int unsigned io,
                                             input int unsigned rc);
    int unsigned base;
    case (sel)
      2'd0:    base = xt;
      2'd1:    base = io;
      default: base = rc;
    endcase
    base = at_least_one(base);
    return long_sel ? (base * 2) : base;
  endfunction

endpackage

// File: rtl/por_detect.sv
module por_detect
  import por_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vdd_ok,
  input  logic             vdd_live,
  input  logic [SEL_W-1:0] cfg_clk_sel,
  input  logic             cfg_long_start,
  output logic             pon_evt,
  output logic [SEL_W-1:0] sel_q,
  output logic             long_q
);

  logic armed_q;

  assign pon_evt = vdd_ok && vdd_live && armed_q;

  // rearm on the low level only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
    end else if (!vdd_live) begin
      armed_q <= 1'b1;
    end else if (pon_evt) begin
      armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      long_q <= 1'b0;
    end else if (pon_evt) begin
      sel_q  <= cfg_clk_sel;
      long_q <= cfg_long_start;
    end
  end

  assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pon_evt |=> !pon_evt);

  assert_sel_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pon_evt |=> (sel_q == $past(cfg_clk_sel)));

endmodule

// File: rtl/por_timer.sv
module por_timer
  import por_seq_pkg::*;
#(
  parameter int unsigned BIAS_CYC   = 4,
  parameter int unsigned PWRT_CYC   = 2048,
  parameter int unsigned XTAL_CYC   = 1024,
  parameter int unsigned INTOSC_CYC = 64,
  parameter int unsigned RC_CYC     = 16,
  parameter int unsigned CNT_W      = 13
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vdd_ok,
  input  logic [SEL_W-1:0] sel_q,
  input  logic             long_q,
  output seq_state_t       state_q,
  output logic             seq_done
);

  localparam logic [CNT_W-1:0] BIAS_LOAD = CNT_W'(at_least_one(BIAS_CYC) - 1);
  localparam logic [CNT_W-1:0] PWRT_LOAD = CNT_W'(at_least_one(PWRT_CYC) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  seq_state_t       state_d;
  logic             cnt_zero;
  int unsigned      clk_wait;

  assign cnt_zero = (cnt_q == '0);
  assign clk_wait = start_wait(sel_q, long_q, XTAL_CYC, INTOSC_CYC, RC_CYC);
  assign seq_done = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!vdd_ok) begin
      state_d = ST_IDLE_RESET;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE_RESET: begin
          state_d = ST_BIAS_WAIT;
          cnt_d   = BIAS_LOAD;
        end
        ST_BIAS_WAIT: begin
          if (cnt_zero) begin
            state_d = ST_PWRT_WAIT;
            cnt_d   = PWRT_LOAD;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_PWRT_WAIT: begin
          if (cnt_zero) begin
            state_d = ST_CLK_WAIT;
            cnt_d   = CNT_W'(clk_wait - 1);
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_CLK_WAIT: begin
          if (cnt_zero) begin
            state_d = ST_RUN;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE_RESET;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_supply_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_ok |=> (state_q == ST_IDLE_RESET));

  assert_pwrt_before_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CLK_WAIT && $past(state_q) != ST_CLK_WAIT) |-> ($past(state_q) == ST_PWRT_WAIT));

  assert_bias_before_pwrt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PWRT_WAIT && $past(state_q) != ST_PWRT_WAIT) |-> ($past(state_q) == ST_BIAS_WAIT));

endmodule

// File: rtl/por_flags.sv
module por_flags
  import por_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pon_evt,
  input  logic              sw_we,
  input  logic [FLAG_W-1:0] sw_wdata,
  output logic [FLAG_W-1:0] flags_q
);

  logic [FLAG_W-1:0] hw_image;

  always_comb begin
    hw_image              = '0;
    hw_image[FLAG_VDDEVT] = 1'b1;
  end

  // hardware event takes priority over the software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (pon_evt) begin
      flags_q <= hw_image;
    end else if (sw_we) begin
      flags_q <= sw_wdata;
    end
  end

  assert_event_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pon_evt |=> (!flags_q[FLAG_POR] && !flags_q[FLAG_BOR] && flags_q[FLAG_VDDEVT]));

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pon_evt && !sw_we) |=> $stable(flags_q));

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
  import por_seq_pkg::*;
#(
  parameter int unsigned BIAS_CYC   = 4,
  parameter int unsigned PWRT_CYC   = 2048,
  parameter int unsigned XTAL_CYC   = 1024,
  parameter int unsigned INTOSC_CYC = 64,
  parameter int unsigned RC_CYC     = 16
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vdd_ok,
  input  logic       vdd_live,
  input  logic       bor_event,
  input  logic       ext_rst_req,
  input  logic [1:0] cfg_clk_sel,
  input  logic       cfg_long_start,
  input  logic       sw_we,
  input  logic [2:0] sw_wdata,
  output logic       rst_int,
  output logic       clk_en,
  output logic       exec_en,
  output logic [1:0] clk_sel_q,
  output logic [2:0] rst_flags
);

  localparam int unsigned MAX_OSC = 2 * max2(max2(at_least_one(XTAL_CYC), at_least_one(INTOSC_CYC)),
                                             at_least_one(RC_CYC));
  localparam int unsigned MAX_LEN = max2(max2(at_least_one(PWRT_CYC), at_least_one(BIAS_CYC)), MAX_OSC);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1) + 1;

  logic       pon_evt;
  logic       long_q;
  logic       seq_done;
  logic       src_hold_q;
  seq_state_t seq_state;

  por_detect u_detect (
    .clk            (clk),
    .rst_n          (rst_n),
    .vdd_ok         (vdd_ok),
    .vdd_live       (vdd_live),
    .cfg_clk_sel    (cfg_clk_sel),
    .cfg_long_start (cfg_long_start),
    .pon_evt        (pon_evt),
    .sel_q          (clk_sel_q),
    .long_q         (long_q)
  );

  por_timer #(
    .BIAS_CYC   (BIAS_CYC),
    .PWRT_CYC   (PWRT_CYC),
    .XTAL_CYC   (XTAL_CYC),
    .INTOSC_CYC (INTOSC_CYC),
    .RC_CYC     (RC_CYC),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .vdd_ok   (vdd_ok),
    .sel_q    (clk_sel_q),
    .long_q   (long_q),
    .state_q  (seq_state),
    .seq_done (seq_done)
  );

  por_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .pon_evt  (pon_evt),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .flags_q  (rst_flags)
  );

  // warm reset requests hold reset without touching the sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_hold_q <= 1'b0;
    end else begin
      src_hold_q <= bor_event || ext_rst_req;
    end
  end

  assign clk_en  = seq_done;
  assign rst_int = !seq_done || src_hold_q;
  assign exec_en = !rst_int;

  assert_release_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |-> clk_en);

  assert_event_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pon_evt |=> (seq_state == ST_BIAS_WAIT));

  assert_warm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_event || ext_rst_req) |=> (rst_int && !exec_en));

endmodule

// File: tb/por_sequencer_bench.sv
module por_sequencer_bench;

  localparam int B  = 3;
  localparam int P  = 8;
  localparam int XT = 5;
  localparam int IO = 4;
  localparam int RC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vdd_ok = 1'b0, vdd_live = 1'b0, bor_event = 1'b0, ext_rst_req = 1'b0;
  logic [1:0] cfg_clk_sel = 2'd0;
  logic       cfg_long_start = 1'b0, sw_we = 1'b0;
  logic [2:0] sw_wdata = 3'd0;
  logic       rst_int, clk_en, exec_en;
  logic [1:0] clk_sel_q;
  logic [2:0] rst_flags;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  por_sequencer #(.BIAS_CYC(B), .PWRT_CYC(P), .XTAL_CYC(XT), .INTOSC_CYC(IO), .RC_CYC(RC)) u_por_sequencer (
    .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .vdd_live(vdd_live), .bor_event(bor_event),
    .ext_rst_req(ext_rst_req), .cfg_clk_sel(cfg_clk_sel), .cfg_long_start(cfg_long_start),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .rst_int(rst_int), .clk_en(clk_en), .exec_en(exec_en),
    .clk_sel_q(clk_sel_q), .rst_flags(rst_flags));

  function automatic int osc_wait(input int s, input bit l);
    int b;
    if (s == 0) b = XT;
    else if (s == 1) b = IO;
    else b = RC;
    return l ? 2 * b : b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: remaining-cycles countdown
  bit m_armed = 1, m_idle = 1, m_long = 0, m_hold = 0;
  int m_left = 0, m_sel = 0;
  bit [2:0] m_flags = 0;

  always @(posedge clk) begin
    bit ev;
    cyc++;
    if (!rst_n) begin
      m_armed = 1; m_idle = 1; m_left = 0; m_sel = 0; m_long = 0; m_hold = 0; m_flags = 0;
    end else begin
      ev = vdd_ok && vdd_live && m_armed;
      if (!vdd_live) m_armed = 1;
      else if (ev) m_armed = 0;
      if (ev) begin m_sel = cfg_clk_sel; m_long = cfg_long_start; end
      if (!vdd_ok) begin m_idle = 1; m_left = 0; end
      else if (m_idle) begin m_idle = 0; m_left = B + P + osc_wait(m_sel, m_long); end
      else if (m_left > 0) m_left--;
      if (ev) m_flags = 3'b100;
      else if (sw_we) m_flags = sw_wdata;
      m_hold = bor_event || ext_rst_req;
    end
  end

  always @(negedge clk) begin
    bit run;
    if (rst_n) begin
      run = !m_idle && (m_left == 0);
      chk("R6 clk_en", clk_en, run);
      chk("R8 exec_en", exec_en, run && !m_hold);
      chk("R7 rst_int", rst_int, !(run && !m_hold));
      chk("R3 clk_sel_q", clk_sel_q, m_sel);
      chk("R10 rst_flags", rst_flags, m_flags);
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL R4 watchdog act=%0d exp=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic count_release(input string req, input int exp);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!exec_en && k < 500);
    chk(req, k, exp);
  endtask

  task automatic power_up(input int sel, input bit l);
    @(negedge clk);
    cfg_clk_sel = 2'(sel); cfg_long_start = l; vdd_live = 1; vdd_ok = 1;
    count_release("R4 R5 release cycles", B + P + osc_wait(sel, l) + 1);
    chk("R9 flags after event", rst_flags, 3'b100);
    chk("R3 latched sel", clk_sel_q, sel);
  endtask

  task automatic power_down();
    @(negedge clk);
    vdd_ok = 0; vdd_live = 0;
    repeat (3) @(negedge clk);
    chk("R7 reset on drop", rst_int, 1);
    chk("R7 clock off on drop", clk_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 rst_int in reset", rst_int, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R11 rst_int", rst_int, 1);
    chk("R11 clk_en", clk_en, 0);
    chk("R11 exec_en", exec_en, 0);
    chk("R11 flags", rst_flags, 0);

    power_up(0, 0); power_down();
    power_up(1, 0); power_down();
    power_up(2, 0); power_down();
    power_up(3, 1);

    // R10 software write and clear
    @(negedge clk); sw_we = 1; sw_wdata = 3'b011;
    @(negedge clk); sw_we = 0;
    chk("R10 write sets", rst_flags, 3'b011);

    // R8 brown-out hold in run
    @(negedge clk); bor_event = 1;
    @(negedge clk);
    chk("R8 bor holds reset", exec_en, 0);
    chk("R8 bor keeps clock", clk_en, 1);
    chk("R8 bor keeps flags", rst_flags, 3'b011);
    bor_event = 0;
    @(negedge clk);
    chk("R8 bor release", exec_en, 1);
    ext_rst_req = 1;
    @(negedge clk); ext_rst_req = 0;
    chk("R8 other source holds", exec_en, 0);
    @(negedge clk);

    // R2 R7 dip without true power-down, then mid-sequence glitch
    cfg_clk_sel = 2'd0; cfg_long_start = 0;
    vdd_ok = 0;
    repeat (2) @(negedge clk);
    chk("R7 dip resets", rst_int, 1);
    vdd_ok = 1;
    repeat (5) @(negedge clk);
    vdd_ok = 0;
    @(negedge clk);
    vdd_ok = 1;
    count_release("R4 R7 full restart after glitch", B + P + osc_wait(3, 1) + 1);
    chk("R2 no relatch", clk_sel_q, 3);
    chk("R2 flags unchanged", rst_flags, 3'b011);

    // R9 event collides with a software write
    power_down();
    @(negedge clk);
    vdd_live = 1; vdd_ok = 1; cfg_clk_sel = 2'd1; sw_we = 1; sw_wdata = 3'b001;
    @(negedge clk); sw_we = 0;
    chk("R9 event wins over write", rst_flags, 3'b100);
    @(negedge clk); sw_we = 1; sw_wdata = 3'b000;
    @(negedge clk); sw_we = 0;
    chk("R10 write clears", rst_flags, 3'b000);
    repeat (30) @(negedge clk);
    chk("R1 R6 running", exec_en, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule